// File: doc/BRIEF.md
# Banked Video Memory Host Port

This block is the slave side of a host bus that reaches into video memory. The host presents a byte address, an access size, a read or write strobe, write data and a bank number. The block turns each access into a single 16-bit word operation on one of three targets. The first is a two-bank backing memory. The second is a sixteen-entry register file, which appears as a window that can be moved over the memory. The third is a colour palette, which can only be written.

The word offset is the byte address shifted right by one. Offsets inside the register window go to the register file and take priority over memory. All other offsets in the host window select a word in the chosen bank. One fixed offset outside the host window is the palette port. Each write there fills the palette entry picked by an internal index, and the index then steps on and wraps after 16 entries. Any access the block cannot serve raises a one-cycle error pulse and has no side effect.

The window base is held in a register. It takes a new value when the load input is pulsed and returns to its default on reset.

Top module: `vmem_host_port`

## Requirements
- R1: Only an access with size code 1 (two bytes) and byte address bit 0 equal to 0 is legal. Size codes 0 (one byte), 2 (four bytes) and 3 (reserved), and odd addresses, give `hst_err` high for one cycle. No memory, register or palette strobe is raised for such an access.
- R2: An access with a bank number of 2 or 3 is an error and has no side effect. This holds for the register window and the palette offset as well.
- R3: A word offset of 0x10000 or above is an error. The one exception is a write to the palette offset.
- R4: A legal access outside the register window raises `mem_en` with `mem_addr` = bank × 0x10000 + offset. `mem_we` is set for writes and `mem_wdata` carries the host data. All of these appear one cycle after the strobe.
- R5: A word offset from the window base up to the base plus 15 raises `rf_en` instead of `mem_en`, with `rf_idx` = offset − base. This holds for reads and writes in either legal bank.
- R6: The window base is word offset 0x200 after reset. When `base_ld` is high for a cycle, the base takes the value of `base_word`.
- R7: A write to word offset 0x40000 (byte address 0x80000) raises `pal_we` with `pal_data` = write data and `pal_idx` = current index. The index then advances modulo 16, and it is 0 after reset.
- R8: A read from the palette offset is an error, and it does not advance the palette index.
- R9: A legal read returns its word on `hst_rdata` with `hst_rvalid` high two cycles after the strobe. The word comes from `rf_rdata` for a register read and from `mem_rdata` for a memory read.
- R10: A cycle with both `hst_rd` and `hst_wr` high is an error.
- R11: In any cycle at most one of `mem_en`, `rf_en`, `pal_we` and `hst_err` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_rd | input | 1 | Read strobe, one cycle per access |
| hst_wr | input | 1 | Write strobe, one cycle per access |
| hst_size | input | 2 | Size code: 0 byte, 1 two bytes, 2 four bytes |
| hst_addr | input | 20 | Byte address |
| hst_wdata | input | 16 | Write data |
| hst_bank | input | 2 | Bank number for memory accesses |
| base_ld | input | 1 | Load the register window base |
| base_word | input | 16 | New window base, word offset |
| hst_rdata | output | 16 | Read data |
| hst_rvalid | output | 1 | Read data valid |
| hst_err | output | 1 | Illegal access pulse |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 17 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after `mem_en` |
| rf_en | output | 1 | Register file access enable |
| rf_we | output | 1 | Register file write enable |
| rf_idx | output | 4 | Register index |
| rf_wdata | output | 16 | Register write data |
| rf_rdata | input | 16 | Register read data, one cycle after `rf_en` |
| pal_we | output | 1 | Palette write strobe |
| pal_idx | output | 4 | Palette entry being written |
| pal_data | output | 16 | Palette write data |

## Verification
The target strobes, the addresses and `hst_err` are registered once, so they are due at the first rising edge after the cycle in which the host strobe is driven. Read data needs one more edge, because the external memory or register file registers it. It is therefore due together with `hst_rvalid` at the second edge. Each access in the bench takes exactly two cycles. The control outputs are sampled 1 ns after the first edge and the read return 1 ns after the second, so accesses never overlap and no sample lands on an edge.

// File: rtl/vmem_pkg.sv
package vmem_pkg;

    localparam int unsigned DATA_W   = 16;
    localparam int unsigned ADDR_W   = 20;
    localparam int unsigned WIN_AW   = 16;
    localparam int unsigned BANKS    = 2;
    localparam int unsigned BANK_W   = 2;
    localparam int unsigned RF_AW    = 4;
    localparam int unsigned PAL_AW   = 4;

    localparam logic [1:0] SIZE_HALF = 2'd1;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_MEM,
        ACC_REG,
        ACC_PAL,
        ACC_ERR
    } acc_kind_e;

    function automatic logic shape_ok(input logic [1:0] size, input logic lsb);
        return (size == SIZE_HALF) && !lsb;
    endfunction

endpackage

// File: rtl/vmem_decode.sv
module vmem_decode
    import vmem_pkg::*;
#(
    parameter int unsigned ADDR_W_P = ADDR_W,
    parameter int unsigned WIN_AW_P = WIN_AW,
    parameter int unsigned BANKS_P  = BANKS,
    parameter int unsigned BANK_W_P = BANK_W,
    parameter int unsigned RF_AW_P  = RF_AW,
    parameter int unsigned PAL_WORD = 32'h40000
) (
    input  logic                              rd,
    input  logic                              wr,
    input  logic [1:0]                        size,
    input  logic [ADDR_W_P-1:0]               addr,
    input  logic [BANK_W_P-1:0]               bank,
    input  logic [WIN_AW_P-1:0]               base,
    output acc_kind_e                         kind,
    output logic [WIN_AW_P+$clog2(BANKS_P)-1:0] mem_addr,
    output logic [RF_AW_P-1:0]                rf_idx
);
    localparam int unsigned OFF_W = ADDR_W_P - 1;
    localparam int unsigned SEL_W = $clog2(BANKS_P);
    localparam logic [BANK_W_P-1:0] BANK_LIM = BANK_W_P'(BANKS_P);
    localparam logic [WIN_AW_P-1:0] RF_SPAN  = WIN_AW_P'(1 << RF_AW_P);

    logic [OFF_W-1:0]    off;
    logic [WIN_AW_P-1:0] woff;
    logic [WIN_AW_P-1:0] rel;
    logic                in_win, is_pal, in_reg;

    assign off    = addr[ADDR_W_P-1:1];
    assign woff   = off[WIN_AW_P-1:0];
    assign in_win = (off[OFF_W-1:WIN_AW_P] == '0);
    assign is_pal = (off == OFF_W'(PAL_WORD));
    assign rel    = woff - base;
    assign in_reg = (woff >= base) && (rel < RF_SPAN);

    assign mem_addr = {bank[SEL_W-1:0], woff};
    assign rf_idx   = rel[RF_AW_P-1:0];

    always_comb begin
        if (!rd && !wr)                         kind = ACC_NONE;
        else if (rd && wr)                      kind = ACC_ERR;
        else if (!shape_ok(size, addr[0]))      kind = ACC_ERR;
        else if (bank >= BANK_LIM)              kind = ACC_ERR;
        else if (is_pal)                        kind = wr ? ACC_PAL : ACC_ERR;
        else if (!in_win)                       kind = ACC_ERR;
        else if (in_reg)                        kind = ACC_REG;
        else                                    kind = ACC_MEM;
    end

    always_comb begin
        if (kind == ACC_PAL) assert (wr && !rd) else $error("p_pal_write_only_r8");
        if (kind == ACC_REG) assert (woff >= base) else $error("p_reg_above_base_r5");
    end
endmodule

// File: rtl/vmem_pal_ptr.sv
module vmem_pal_ptr
    import vmem_pkg::*;
#(
    parameter int unsigned IDX_W = PAL_AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [IDX_W-1:0] idx
);
    always_ff @(posedge clk) begin
        if (rst)       idx <= '0;
        else if (step) idx <= idx + 1'b1;
    end

    p_pal_step_r7: assert property (@(posedge clk) disable iff (rst)
        step |=> idx == IDX_W'($past(idx) + 1'b1));

    p_pal_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(idx));
endmodule

// File: rtl/vmem_host_port.sv
module vmem_host_port
    import vmem_pkg::*;
#(
    parameter int unsigned DATA_W_P = DATA_W,
    parameter int unsigned ADDR_W_P = ADDR_W,
    parameter int unsigned WIN_AW_P = WIN_AW,
    parameter int unsigned BANKS_P  = BANKS,
    parameter int unsigned BANK_W_P = BANK_W,
    parameter int unsigned RF_AW_P  = RF_AW,
    parameter int unsigned PAL_AW_P = PAL_AW,
    parameter int unsigned PAL_WORD = 32'h40000,
    parameter int unsigned BASE_RST = 32'h200,
    localparam int unsigned MEM_AW  = WIN_AW_P + $clog2(BANKS_P)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hst_rd,
    input  logic                hst_wr,
    input  logic [1:0]          hst_size,
    input  logic [ADDR_W_P-1:0] hst_addr,
    input  logic [DATA_W_P-1:0] hst_wdata,
    input  logic [BANK_W_P-1:0] hst_bank,
    input  logic                base_ld,
    input  logic [WIN_AW_P-1:0] base_word,
    output logic [DATA_W_P-1:0] hst_rdata,
    output logic                hst_rvalid,
    output logic                hst_err,
    output logic                mem_en,
    output logic                mem_we,
    output logic [MEM_AW-1:0]   mem_addr,
    output logic [DATA_W_P-1:0] mem_wdata,
    input  logic [DATA_W_P-1:0] mem_rdata,
    output logic                rf_en,
    output logic                rf_we,
    output logic [RF_AW_P-1:0]  rf_idx,
    output logic [DATA_W_P-1:0] rf_wdata,
    input  logic [DATA_W_P-1:0] rf_rdata,
    output logic                pal_we,
    output logic [PAL_AW_P-1:0] pal_idx,
    output logic [DATA_W_P-1:0] pal_data
);
    localparam logic [WIN_AW_P-1:0] BASE_DEF = WIN_AW_P'(BASE_RST);

    logic [WIN_AW_P-1:0] base_q;
    acc_kind_e           dec_kind, kind_q;
    logic [MEM_AW-1:0]   dec_maddr, maddr_q;
    logic [RF_AW_P-1:0]  dec_ridx, ridx_q;
    logic [DATA_W_P-1:0] wdata_q;
    logic                wr_q;
    logic                ret_q, ret_rf_q;

    always_ff @(posedge clk) begin
        if (rst)          base_q <= BASE_DEF;
        else if (base_ld) base_q <= base_word;
    end

    vmem_decode #(
        .ADDR_W_P(ADDR_W_P), .WIN_AW_P(WIN_AW_P), .BANKS_P(BANKS_P),
        .BANK_W_P(BANK_W_P), .RF_AW_P(RF_AW_P), .PAL_WORD(PAL_WORD)
    ) u_dec (
        .rd(hst_rd), .wr(hst_wr), .size(hst_size), .addr(hst_addr),
        .bank(hst_bank), .base(base_q),
        .kind(dec_kind), .mem_addr(dec_maddr), .rf_idx(dec_ridx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= ACC_NONE;
            maddr_q <= '0;
            ridx_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
        end else begin
            kind_q  <= dec_kind;
            maddr_q <= dec_maddr;
            ridx_q  <= dec_ridx;
            wdata_q <= hst_wdata;
            wr_q    <= hst_wr;
        end
    end

    assign mem_en    = (kind_q == ACC_MEM);
    assign mem_we    = mem_en && wr_q;
    assign mem_addr  = maddr_q;
    assign mem_wdata = wdata_q;
    assign rf_en     = (kind_q == ACC_REG);
    assign rf_we     = rf_en && wr_q;
    assign rf_idx    = ridx_q;
    assign rf_wdata  = wdata_q;
    assign pal_we    = (kind_q == ACC_PAL);
    assign pal_data  = wdata_q;
    assign hst_err   = (kind_q == ACC_ERR);

    vmem_pal_ptr #(.IDX_W(PAL_AW_P)) u_pal (
        .clk(clk), .rst(rst), .step(pal_we), .idx(pal_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ret_q    <= 1'b0;
            ret_rf_q <= 1'b0;
        end else begin
            ret_q    <= (mem_en || rf_en) && !wr_q;
            ret_rf_q <= rf_en;
        end
    end

    assign hst_rvalid = ret_q;
    assign hst_rdata  = ret_rf_q ? rf_rdata : mem_rdata;

    p_one_target_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_en, rf_en, pal_we, hst_err}));

    p_err_has_cause_r1: assert property (@(posedge clk) disable iff (rst)
        hst_err |-> $past(hst_rd || hst_wr));

    p_read_returns_r9: assert property (@(posedge clk) disable iff (rst)
        ((mem_en && !mem_we) || (rf_en && !rf_we)) |=> hst_rvalid);

    p_both_strobes_r10: assert property (@(posedge clk) disable iff (rst)
        (hst_rd && hst_wr) |=> hst_err);

    p_base_default_r6: assert property (@(posedge clk)
        rst |=> base_q == BASE_DEF);
endmodule

// File: tb/tb_vmem_host_port.sv
`timescale 1ns/1ps
module tb_vmem_host_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hst_rd = 1'b0, hst_wr = 1'b0;
    logic [1:0]  hst_size = 2'd1;
    logic [19:0] hst_addr = '0;
    logic [15:0] hst_wdata = '0;
    logic [1:0]  hst_bank = '0;
    logic        base_ld = 1'b0;
    logic [15:0] base_word = '0;
    logic [15:0] hst_rdata, mem_wdata, rf_wdata, pal_data;
    logic [15:0] mem_rdata = '0, rf_rdata = '0;
    logic        hst_rvalid, hst_err, mem_en, mem_we, rf_en, rf_we, pal_we;
    logic [16:0] mem_addr;
    logic [3:0]  rf_idx, pal_idx;

    int applied = 0;
    int misses  = 0;

    always #2 clk = ~clk;

    vmem_host_port dut (
        .clk, .rst, .hst_rd, .hst_wr, .hst_size, .hst_addr, .hst_wdata, .hst_bank,
        .base_ld, .base_word, .hst_rdata, .hst_rvalid, .hst_err,
        .mem_en, .mem_we, .mem_addr, .mem_wdata, .mem_rdata,
        .rf_en, .rf_we, .rf_idx, .rf_wdata, .rf_rdata,
        .pal_we, .pal_idx, .pal_data
    );

    always_ff @(posedge clk) begin
        if (mem_en && !mem_we) mem_rdata <= mem_addr[15:0] ^ 16'hA5C3;
        if (rf_en && !rf_we)   rf_rdata  <= {12'hC0D, rf_idx};
    end

    localparam logic [1:0] K_MEM = 2'd0, K_RF = 2'd1, K_PAL = 2'd2, K_ERR = 2'd3;

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic [1:0]  size;
        logic [1:0]  bank;
        logic [19:0] addr;
        logic [15:0] wdata;
        logic [1:0]  kind;
        logic [16:0] eaddr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,2'd1,2'd0,20'h00010,16'h1111,K_MEM,17'h00008,4'd4},  // R4 write bank0
        '{1'b1,1'b0,2'd1,2'd1,20'h1FFFE,16'h0000,K_MEM,17'h1FFFF,4'd4},  // R4 top of bank1
        '{1'b0,1'b1,2'd1,2'd1,20'h00400,16'h2222,K_RF ,17'h00000,4'd5},  // R5 first reg, bank1
        '{1'b1,1'b0,2'd1,2'd0,20'h0041E,16'h0000,K_RF ,17'h0000F,4'd5},  // R5 last reg
        '{1'b1,1'b0,2'd1,2'd0,20'h00420,16'h0000,K_MEM,17'h00210,4'd5},  // R5 just above window
        '{1'b1,1'b0,2'd1,2'd0,20'h003FE,16'h0000,K_MEM,17'h001FF,4'd5},  // R5 just below window
        '{1'b0,1'b1,2'd0,2'd0,20'h00010,16'h3333,K_ERR,17'h00000,4'd1},  // R1 byte size
        '{1'b0,1'b1,2'd2,2'd0,20'h00010,16'h3333,K_ERR,17'h00000,4'd1},  // R1 word size
        '{1'b1,1'b0,2'd1,2'd0,20'h00011,16'h0000,K_ERR,17'h00000,4'd1},  // R1 odd address
        '{1'b1,1'b0,2'd1,2'd2,20'h00010,16'h0000,K_ERR,17'h00000,4'd2},  // R2 bank 2
        '{1'b0,1'b1,2'd1,2'd3,20'h80000,16'h4444,K_ERR,17'h00000,4'd2},  // R2 bank 3 palette
        '{1'b1,1'b0,2'd1,2'd0,20'h20000,16'h0000,K_ERR,17'h00000,4'd3},  // R3 read past window
        '{1'b0,1'b1,2'd1,2'd0,20'h20000,16'h5555,K_ERR,17'h00000,4'd3},  // R3 write past window
        '{1'b0,1'b1,2'd1,2'd0,20'h80000,16'h6666,K_PAL,17'h00000,4'd7},  // R7 first palette entry
        '{1'b1,1'b0,2'd1,2'd0,20'h80000,16'h0000,K_ERR,17'h00000,4'd8},  // R8 palette read
        '{1'b1,1'b1,2'd1,2'd0,20'h00010,16'h7777,K_ERR,17'h00000,4'd10}, // R10 both strobes
        '{1'b0,1'b1,2'd1,2'd0,20'h80000,16'h8888,K_PAL,17'h00001,4'd7}   // R7, R8 index unchanged by errors
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (!ok) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v, input string tag);
        logic [5:0]  eflags;
        logic [5:0]  aflags;
        logic [15:0] erd;
        @(negedge clk);
        hst_rd = v.rd; hst_wr = v.wr; hst_size = v.size;
        hst_bank = v.bank; hst_addr = v.addr; hst_wdata = v.wdata;
        case (v.kind)
            K_MEM:   eflags = {1'b1, v.wr, 4'b0000};
            K_RF:    eflags = {2'b00, 1'b1, v.wr, 2'b00};
            K_PAL:   eflags = 6'b000010;
            default: eflags = 6'b000001;
        endcase
        @(posedge clk); #1;
        aflags = {mem_en, mem_we, rf_en, rf_we, pal_we, hst_err};
        check(aflags == eflags, {tag, " strobes"}, 32'(aflags), 32'(eflags));
        if (v.kind == K_MEM)
            check(mem_addr == v.eaddr, {tag, " mem_addr"}, 32'(mem_addr), 32'(v.eaddr));
        if (v.kind == K_RF)
            check(rf_idx == v.eaddr[3:0], {tag, " rf_idx"}, 32'(rf_idx), 32'(v.eaddr[3:0]));
        if (v.kind == K_PAL)
            check(pal_idx == v.eaddr[3:0] && pal_data == v.wdata, {tag, " palette"},
                  {pal_idx, 12'h0, pal_data}, {v.eaddr[3:0], 12'h0, v.wdata});
        if (v.wr && v.kind == K_MEM)
            check(mem_wdata == v.wdata, {tag, " mem_wdata"}, 32'(mem_wdata), 32'(v.wdata));
        if (v.wr && v.kind == K_RF)
            check(rf_wdata == v.wdata, {tag, " rf_wdata"}, 32'(rf_wdata), 32'(v.wdata));
        @(negedge clk);
        hst_rd = 1'b0; hst_wr = 1'b0;
        @(posedge clk); #1;
        if (v.rd && !v.wr && (v.kind == K_MEM || v.kind == K_RF)) begin
            erd = (v.kind == K_RF) ? {12'hC0D, v.eaddr[3:0]} : (v.eaddr[15:0] ^ 16'hA5C3);
            check(hst_rvalid && hst_rdata == erd, {tag, " R9 read data"},
                  {15'h0, hst_rvalid, hst_rdata}, {15'h0, 1'b1, erd});
        end else begin
            check(!hst_rvalid, {tag, " R9 no read return"}, 32'(hst_rvalid), 32'h0);
        end
    endtask

    function automatic vec_t mk(input logic rd, input logic wr, input logic [19:0] addr,
                                input logic [15:0] wd, input logic [1:0] k, input logic [16:0] ea);
        return '{rd, wr, 2'd1, 2'd0, addr, wd, k, ea, 4'd0};
    endfunction

    initial begin
        #(200000 * 4);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", applied, misses);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check({mem_en, rf_en, pal_we, hst_err, hst_rvalid} == 5'b0, "R11 reset outputs idle",
              32'({mem_en, rf_en, pal_we, hst_err, hst_rvalid}), 32'h0);

        for (int i = 0; i < NV; i++)
            apply(VECS[i], $sformatf("R%0d vec%0d", VECS[i].req, i));

        // R6: move the window to word 0x1000
        @(negedge clk); base_ld = 1'b1; base_word = 16'h1000;
        @(negedge clk); base_ld = 1'b0;
        apply(mk(1'b0, 1'b1, 20'h02006, 16'h9999, K_RF, 17'h3), "R6 moved base reg3");
        apply(mk(1'b1, 1'b0, 20'h00400, 16'h0, K_MEM, 17'h200), "R6 old base now memory");

        // R7: walk the palette index to 15 and wrap
        for (int j = 2; j <= 16; j++)
            apply(mk(1'b0, 1'b1, 20'h80000, 16'(j * 3), K_PAL, 17'(j % 16)), "R7 palette walk");

        // R6, R7: reset restores base and index
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        apply(mk(1'b0, 1'b1, 20'h80000, 16'hABCD, K_PAL, 17'h0), "R7 index after reset");
        apply(mk(1'b1, 1'b0, 20'h00400, 16'h0, K_RF, 17'h0), "R6 base after reset");
        apply(mk(1'b1, 1'b0, 20'h02000, 16'h0, K_MEM, 17'h1000), "R6 loaded base cleared");

        $display("  == %0d vectors applied, %0d miscompares ==", applied, misses);
        $finish;
    end
endmodule